// File: doc/BRIEF.md
# Dual GPIO Port Register Block with NAND and Serial-Sensor Sideband

This block is a small word-addressed register file holding two general-purpose ports, called A and D. Each port has three registers: a data-out word, a data-in view and an output-enable word. A host reaches them through a single 32-bit request port that carries one read or one write per cycle. Every read is answered one cycle later with a one-cycle response strobe.

Some register writes also act on pins. Bits 6, 5 and 4 of the port A data-out word drive the address-latch, command-latch and chip-enable strobes of an attached NAND flash. A write to the port D data-out word that flips bit 1 counts as a bit-banged serial clock edge. The block reports that edge toward a serial sensor as a one-cycle event carrying the new clock level and the data bit, bit 4. The event has no ready input, so the sensor side must accept a pulse in any cycle.

A read of a data-in view merges live status into the result. That result is the port's data-out word masked by its output-enable word, with the NAND ready pin spliced into port A bit 7 and the sensor's serial output pin spliced into port D bit 4. All other words inside the window are plain storage.

Top module: `gpio_sideband_regs`

## Requirements
- R1: After a synchronous active-high reset, every stored word is zero, the three NAND strobes are low, no sensor event is pending and no read response is pending.
- R2: The word index is `bus_addr[6:2]`, and `bus_addr[1:0]` has no effect. The window covers indices 0 to 22. A write with an index of 23 or above changes nothing, and a read with such an index returns zero.
- R3: Every in-window index other than 1 and 17 reads back the last value written to it. The data-out and output-enable registers of port A sit at indices 0 and 2, and those of port D at indices 16 and 18.
- R4: A read of index 1 returns (word 0 AND word 2) OR (`nand_rdy` shifted into bit 7).
- R5: A read of index 17 returns (word 16 AND word 18) OR (`sens_sdo` shifted into bit 4).
- R6: From the cycle after a write to index 0, `nand_addr_latch` equals bit 6 of the written value, `nand_cmd_latch` equals bit 5 and `nand_chip_en` equals bit 4. The strobes hold their values until the next write to index 0.
- R7: A write to index 16 whose bit 1 differs from bit 1 of the stored word raises `sens_evt_valid` in the next cycle. In that cycle `sens_evt_clk` equals the new bit 1 and `sens_evt_data` equals bit 4 of the written value. A write to index 16 that leaves bit 1 unchanged raises no event.
- R8: A write to index 1 or 17 is stored, but it does not change what a later read of that index returns.
- R9: `bus_rvalid` is high for exactly one cycle, the cycle after a read request. `bus_rdata` holds the response in that cycle.
- R10: An event stays high for exactly one cycle per qualifying write. It cannot stall, so two events in back-to-back cycles always carry opposite clock levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Request strobe, one operation per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address; the word index is bits 6:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| nand_rdy | input | 1 | NAND ready/busy status pin |
| sens_sdo | input | 1 | Sensor serial output pin |
| nand_addr_latch | output | 1 | NAND address-latch strobe |
| nand_cmd_latch | output | 1 | NAND command-latch strobe |
| nand_chip_en | output | 1 | NAND chip-enable level |
| sens_evt_valid | output | 1 | One-cycle serial clock edge event |
| sens_evt_clk | output | 1 | Clock level carried by the event |
| sens_evt_data | output | 1 | Data bit carried by the event |

## Verification
The assertions assume that `bus_addr` and `bus_we` hold known values whenever `bus_req` is high. They also assume the sensor side takes every event pulse in the cycle it appears, because no ready input exists to stall it. The stimulus meets both assumptions by driving every input at the falling edge with fully defined values. It issues at most one request per two cycles and samples outputs only at falling edges. This keeps each event and each read response isolated in its own cycle, so the bench can attribute it to a single request.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

  // Word index layout of the two ports; the host software depends on it.
  localparam int unsigned PORT_A_BASE = 0;
  localparam int unsigned PORT_D_BASE = 16;
  localparam int unsigned OFS_DOUT    = 0;
  localparam int unsigned OFS_DIN     = 1;
  localparam int unsigned OFS_OE      = 2;

  typedef struct packed {
    logic addr_latch;
    logic cmd_latch;
    logic chip_en;
  } nand_ctl_t;

  typedef struct packed {
    logic valid;
    logic level;
    logic data;
  } sens_evt_t;

endpackage

// File: rtl/gsb_regfile.sv
module gsb_regfile #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 23,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]    regs_q
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        word_q <= wr_data;
      end
    end

    assign regs_q[g] = word_q;
  end

endmodule

// File: rtl/gsb_strobe_dec.sv
module gsb_strobe_dec
  import gsb_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ALE_BIT  = 6,
  parameter int unsigned CLE_BIT  = 5,
  parameter int unsigned CEN_BIT  = 4
) (
  input  logic [DATA_W-1:0] pa_word,
  output nand_ctl_t         ctl
);

  // The remaining bits stay ordinary GPIO data.
  logic unused_pa_bits;
  assign unused_pa_bits = ^pa_word;

  always_comb begin
    ctl.addr_latch = pa_word[ALE_BIT];
    ctl.cmd_latch  = pa_word[CLE_BIT];
    ctl.chip_en    = pa_word[CEN_BIT];
  end

endmodule

// File: rtl/gsb_clk_edge.sv
module gsb_clk_edge
  import gsb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_fire,
  input  logic      new_clk,
  input  logic      new_dat,
  input  logic      old_clk,
  output sens_evt_t evt
);

  sens_evt_t evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
    end else begin
      evt_q.valid <= wr_fire && (new_clk != old_clk);
      if (wr_fire) begin
        evt_q.level <= new_clk;
        evt_q.data  <= new_dat;
      end
    end
  end

  assign evt = evt_q;

endmodule

// File: rtl/gsb_read_mux.sv
module gsb_read_mux
  import gsb_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 23,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned RDY_BIT   = 7,
  parameter int unsigned SDO_BIT   = 4
) (
  input  logic [NUM_WORDS-1:0][DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]                 idx,
  input  logic                             nand_rdy,
  input  logic                             sens_sdo,
  output logic [DATA_W-1:0]                rd_word
);

  localparam logic [IDX_W-1:0] PA_DIN_IDX = IDX_W'(PORT_A_BASE + OFS_DIN);
  localparam logic [IDX_W-1:0] PD_DIN_IDX = IDX_W'(PORT_D_BASE + OFS_DIN);

  logic [DATA_W-1:0] pa_view;
  logic [DATA_W-1:0] pd_view;

  assign pa_view = (regs[PORT_A_BASE + OFS_DOUT] & regs[PORT_A_BASE + OFS_OE])
                 | (DATA_W'(nand_rdy) << RDY_BIT);
  assign pd_view = (regs[PORT_D_BASE + OFS_DOUT] & regs[PORT_D_BASE + OFS_OE])
                 | (DATA_W'(sens_sdo) << SDO_BIT);

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (idx == IDX_W'(i)) rd_word = regs[i];
    end
    if (idx == PA_DIN_IDX) rd_word = pa_view;
    if (idx == PD_DIN_IDX) rd_word = pd_view;
  end

endmodule

// File: rtl/gpio_sideband_regs.sv
module gpio_sideband_regs
  import gsb_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned NUM_WORDS = 23,
  parameter int unsigned ALE_BIT   = 6,
  parameter int unsigned CLE_BIT   = 5,
  parameter int unsigned CEN_BIT   = 4,
  parameter int unsigned RDY_BIT   = 7,
  parameter int unsigned SCLK_BIT  = 1,
  parameter int unsigned SDAT_BIT  = 4,
  parameter int unsigned SDO_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              nand_rdy,
  input  logic              sens_sdo,
  output logic              nand_addr_latch,
  output logic              nand_cmd_latch,
  output logic              nand_chip_en,
  output logic              sens_evt_valid,
  output logic              sens_evt_clk,
  output logic              sens_evt_data
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [IDX_W:0]   WIN_LIM     = (IDX_W+1)'(NUM_WORDS);
  localparam logic [IDX_W-1:0] PA_DOUT_IDX = IDX_W'(PORT_A_BASE + OFS_DOUT);
  localparam logic [IDX_W-1:0] PD_DOUT_IDX = IDX_W'(PORT_D_BASE + OFS_DOUT);

  logic [IDX_W-1:0] idx;
  logic             in_win;
  logic             wr_en;
  logic             rd_fire;
  logic             unused_byte_ofs;

  assign idx             = bus_addr[ADDR_W-1:2];
  assign unused_byte_ofs = ^bus_addr[1:0];
  assign in_win          = ({1'b0, idx} < WIN_LIM);
  assign wr_en           = bus_req && bus_we && in_win;
  assign rd_fire         = bus_req && !bus_we;

  logic [NUM_WORDS-1:0][DATA_W-1:0] regs_q;

  gsb_regfile #(
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) i_regfile (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (bus_wdata),
    .regs_q  (regs_q)
  );

  // Port A data-out to NAND control strobes
  nand_ctl_t nand_ctl;

  gsb_strobe_dec #(
    .DATA_W  (DATA_W),
    .ALE_BIT (ALE_BIT),
    .CLE_BIT (CLE_BIT),
    .CEN_BIT (CEN_BIT)
  ) i_strobe_dec (
    .pa_word (regs_q[PORT_A_BASE + OFS_DOUT]),
    .ctl     (nand_ctl)
  );

  assign nand_addr_latch = nand_ctl.addr_latch;
  assign nand_cmd_latch  = nand_ctl.cmd_latch;
  assign nand_chip_en    = nand_ctl.chip_en;

  // Port D data-out to serial clock edge events
  logic      pd_wr;
  sens_evt_t evt;

  assign pd_wr = wr_en && (idx == PD_DOUT_IDX);

  gsb_clk_edge i_clk_edge (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (pd_wr),
    .new_clk (bus_wdata[SCLK_BIT]),
    .new_dat (bus_wdata[SDAT_BIT]),
    .old_clk (regs_q[PORT_D_BASE + OFS_DOUT][SCLK_BIT]),
    .evt     (evt)
  );

  assign sens_evt_valid = evt.valid;
  assign sens_evt_clk   = evt.level;
  assign sens_evt_data  = evt.data;

  // Read response path
  logic [DATA_W-1:0] rd_word;

  gsb_read_mux #(
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W),
    .RDY_BIT   (RDY_BIT),
    .SDO_BIT   (SDO_BIT)
  ) i_read_mux (
    .regs     (regs_q),
    .idx      (idx),
    .nand_rdy (nand_rdy),
    .sens_sdo (sens_sdo),
    .rd_word  (rd_word)
  );

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= rd_word;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R6
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && idx == PA_DOUT_IDX) |=>
      $stable({nand_addr_latch, nand_cmd_latch, nand_chip_en}));

  // R7
  evt_level_chk: assert property (@(posedge clk) disable iff (rst)
    sens_evt_valid |-> sens_evt_clk == regs_q[PORT_D_BASE + OFS_DOUT][SCLK_BIT]);

  // R7
  evt_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_wr && bus_wdata[SCLK_BIT] != regs_q[PORT_D_BASE + OFS_DOUT][SCLK_BIT])
      |=> sens_evt_valid);

  // R10
  evt_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    sens_evt_valid |=> !sens_evt_valid || (sens_evt_clk != $past(sens_evt_clk)));

  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> bus_rvalid);

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> !bus_rvalid);

endmodule

// File: tb/test_gpio_sideband_regs.sv
module test_gpio_sideband_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        nand_rdy = 1'b0;
  logic        sens_sdo = 1'b0;
  logic        nand_addr_latch, nand_cmd_latch, nand_chip_en;
  logic        sens_evt_valid, sens_evt_clk, sens_evt_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [0:31];

  always #2 clk = ~clk;

  gpio_sideband_regs i_gpio_sideband_regs (
    .clk (clk), .rst (rst),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
    .nand_rdy (nand_rdy), .sens_sdo (sens_sdo),
    .nand_addr_latch (nand_addr_latch), .nand_cmd_latch (nand_cmd_latch),
    .nand_chip_en (nand_chip_en),
    .sens_evt_valid (sens_evt_valid), .sens_evt_clk (sens_evt_clk),
    .sens_evt_data (sens_evt_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    if (a[6:2] < 5'd23) model[a[6:2]] = d;
  endtask

  task automatic do_read(input logic [6:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  function automatic logic [31:0] expect_rd(input int idx, input logic rdy, input logic sdo);
    if (idx >= 23) return 32'h0;
    if (idx == 1)  return (model[0] & model[2]) | (32'(rdy) << 7);
    if (idx == 17) return (model[16] & model[18]) | (32'(sdo) << 4);
    return model[idx];
  endfunction

  function automatic logic [31:0] pattern(input int i);
    return (32'h9E3779B9 * 32'(i + 1)) ^ (32'(i) << 8);
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 strobes", {29'h0, nand_addr_latch, nand_cmd_latch, nand_chip_en}, 32'h0);
    check("R1 event", {31'h0, sens_evt_valid}, 32'h0);
    check("R9 idle rvalid", {31'h0, bus_rvalid}, 32'h0);
    for (int i = 0; i < 23; i++) begin
      do_read(7'(i * 4), rd, rv);
      check("R1 word", rd, 32'h0);
    end

    // R2 R3 R8 address sweep with varying byte offsets, including out-of-window indices
    for (int i = 0; i < 32; i++) do_write(7'(i * 4 + (i % 4)), pattern(i));
    for (int i = 0; i < 32; i++) begin
      nand_rdy = i[0];
      sens_sdo = i[1];
      do_read(7'(i * 4 + ((i + 1) % 4)), rd, rv);
      check("R9 rvalid", {31'h0, rv}, 32'h1);
      if (i >= 23)      check("R2 outside", rd, expect_rd(i, i[0], i[1]));
      else if (i == 1)  check("R4 pa din", rd, expect_rd(i, i[0], i[1]));
      else if (i == 17) check("R5 pd din", rd, expect_rd(i, i[0], i[1]));
      else              check("R3 store", rd, expect_rd(i, i[0], i[1]));
    end
    @(negedge clk);
    check("R9 single rvalid", {31'h0, bus_rvalid}, 32'h0);

    // R8 data-in writes do not change the merged view
    do_write(7'h04, 32'hFFFF_FFFF);
    do_write(7'h44, 32'hFFFF_FFFF);
    nand_rdy = 1'b1; sens_sdo = 1'b0;
    do_read(7'h04, rd, rv);
    check("R8 pa din", rd, (model[0] & model[2]) | 32'h80);
    do_read(7'h44, rd, rv);
    check("R8 pd din", rd, model[16] & model[18]);

    // R4 R5 merge sweep over output-enable masks
    for (int k = 0; k < 8; k++) begin
      do_write(7'h08, 32'h0F0F_0F0F << k);
      do_write(7'h48, 32'hF0F0_F0F0 >> k);
      nand_rdy = k[0]; sens_sdo = k[1];
      do_read(7'h04, rd, rv);
      check("R4 merge", rd, expect_rd(1, k[0], k[1]));
      do_read(7'h44, rd, rv);
      check("R5 merge", rd, expect_rd(17, k[0], k[1]));
    end

    // R6 strobe decode for every combination of bits 6:4
    for (int k = 0; k < 8; k++) begin
      do_write(7'h00, (32'hA5A5_A58F & ~32'h70) | (32'(k) << 4));
      check("R6 strobes", {29'h0, nand_addr_latch, nand_cmd_latch, nand_chip_en}, 32'(k));
      do_write(7'h08, 32'(k) << 4 ^ 32'h70);
      check("R6 hold", {29'h0, nand_addr_latch, nand_cmd_latch, nand_chip_en}, 32'(k));
    end

    // R7 R10 serial clock edge events
    for (int k = 0; k < 16; k++) begin
      logic [31:0] nv;
      logic        exp_v;
      nv = 32'h0000_0200 | (32'(k[0]) << 4) | (32'(k[1] ^ k[2] ^ k[3]) << 1);
      exp_v = nv[1] != model[16][1];
      do_write(7'h40, nv);
      check("R7 event valid", {31'h0, sens_evt_valid}, {31'h0, exp_v});
      if (exp_v) begin
        check("R7 event clk", {31'h0, sens_evt_clk}, {31'h0, nv[1]});
        check("R7 event data", {31'h0, sens_evt_data}, {31'h0, nv[4]});
      end
      @(negedge clk);
      check("R10 one cycle", {31'h0, sens_evt_valid}, 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule